// File: doc/BRIEF.md
# Lane-Space-Gated Dispatch Arbiter

This block picks the next coherence message to hand to a node controller's protocol engine. There are seven candidate sources, each presenting one head flag:

- two processor-side queues, the primary one and a bypass queue;
- four network input queues, one for each incoming virtual lane;
- a software overflow queue.

Sources take turns in a rotating order. A source may win only if its head is valid and every outgoing virtual-lane queue it might write into still has enough free slots. That rule keeps the protocol engine from starting a handler that would then stall on a full output lane, which is the basis of deadlock freedom for the lane dependence graph.

The set of outgoing lanes each source may need is held in a per-source mask. The masks reset to the baseline dependence graph and can be rewritten through a configuration port. The free-slot threshold is a separate register. Free space on a lane is the queue depth minus the occupancy count presented on the ports in the same cycle. The grant is registered and is visible one cycle after the inputs that caused it. A saturating counter records the cycles in which work was waiting but lane space blocked all of it.

Top module: `dispatch_arbiter`

## Requirements
- R1: After reset, `grant_valid` is 0, `stall_count` is 0, the free-slot threshold is 2 and the rotation starts at source 0.
- R2: A source is eligible only when its head flag is 1 and, for every lane whose bit is set in its mask, (queue depth − that lane's occupancy) ≥ threshold. An occupancy above the depth counts as zero free slots. Lane k's occupancy sits at bits [k*CW +: CW] of `lane_occ`.
- R3: A source whose mask is all zero is eligible whenever its head flag is 1, whatever the occupancies are.
- R4: Among eligible sources, the winner is the first one found scanning upward (wrapping from 6 to 0) from the rotation start. After a grant to source i, the start becomes (i+1) mod 7. When there is no grant, the start is unchanged.
- R5: If no source is eligible, `grant_valid` is 0 for that decision.
- R6: The inputs present at a rising clock edge decide the `grant_valid`/`grant_idx` value shown after that edge.
- R7: A write with `cfg_thr_we` loads `cfg_thr_data` as the threshold. It governs decisions from the next edge on.
- R8: A write with `cfg_mask_we` replaces the mask of source `cfg_mask_sel` (bit k = lane k). A selector of 7 or more has no effect.
- R9: Reset masks, with sources 0 = primary processor queue, 1 = bypass queue, 2..5 = network input for lanes 0..3, and 6 = software queue:
  - source 0: {0,2}
  - source 1: {0,1}
  - source 2: {1,2}
  - source 3: {}
  - source 4: {1}
  - source 5: {}
  - source 6: {2}
- R10: `stall_count` rises by 1 for each decision in which some head flag is 1 but no source is eligible. Otherwise it holds. It saturates at its maximum.
- R11: A lane outside a source's mask has no effect on that source's eligibility, even when that lane's queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_valid | input | N_SRC | Head-valid flag per source |
| lane_occ | input | N_LANE*CW | Occupancy count per outgoing lane queue, packed |
| cfg_thr_we | input | 1 | Threshold write strobe |
| cfg_thr_data | input | CW | New free-slot threshold |
| cfg_mask_we | input | 1 | Mask write strobe |
| cfg_mask_sel | input | IW | Source whose mask is written |
| cfg_mask_data | input | N_LANE | New lane mask |
| grant_valid | output | 1 | A source won this decision |
| grant_idx | output | IW | Index of the winning source |
| stall_count | output | STALL_W | Saturating count of lane-space stalls |

## Verification
Four properties hold on every cycle:
- a grant always names a source whose head was valid at the deciding edge;
- a request is never left without a grant;
- a cycle with no request never grants;
- the stall counter steps or holds exactly as R10 says.

The properties cannot show which source should have won, or whether the free-slot arithmetic is right at the threshold boundary. Those come from the bench. It sweeps every head pattern against occupancy values on either side of the threshold, and repeats the sweep after rewriting the threshold and masks. An independent model predicts each winner and the rotation.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

   // Baseline lane dependence per source, bit k = outgoing lane k.
   // Source order: 0 primary CPU queue, 1 bypass queue,
   // 2..5 network input lanes 0..3, 6 software queue.
   function automatic logic [31:0] base_lanes(input int unsigned src);
      case (src)
         0:       base_lanes = 32'b0101;
         1:       base_lanes = 32'b0011;
         2:       base_lanes = 32'b0110;
         4:       base_lanes = 32'b0010;
         6:       base_lanes = 32'b0100;
         default: base_lanes = 32'b0000;
      endcase
   endfunction

   function automatic int unsigned idx_bits(input int unsigned n);
      idx_bits = (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/lane_room_check.sv
module lane_room_check #(
   parameter int unsigned N_LANE = 4,
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned CW     = $clog2(DEPTH + 1)
) (
   input  logic [N_LANE*CW-1:0] occ_flat,
   input  logic [CW-1:0]        thr,
   output logic [N_LANE-1:0]    lane_ok
);
   localparam logic [CW-1:0] DEPTH_W = CW'(DEPTH);

   for (genvar k = 0; k < N_LANE; k++) begin : g_lane
      logic [CW-1:0] occ;
      logic [CW-1:0] room;
      assign occ        = occ_flat[k*CW +: CW];
      assign room       = (occ > DEPTH_W) ? '0 : DEPTH_W - occ;
      assign lane_ok[k] = (room >= thr);
   end
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
   parameter int unsigned N  = 7,
   parameter int unsigned IW = dsa_pkg::idx_bits(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   output logic          gnt_vld,
   output logic [IW-1:0] gnt_idx
);
   localparam bool_pow2 = ((1 << IW) == N);

   logic [IW-1:0] start_q;
   logic [IW-1:0] win;
   logic          hit;

   // Wrap helper: pow2 sizes wrap for free, others subtract N.
   function automatic logic [IW-1:0] wrap_add(input logic [IW-1:0] a,
                                              input logic [IW-1:0] b);
      logic [IW:0] s;
      s = {1'b0, a} + {1'b0, b};
      if (bool_pow2)
         wrap_add = s[IW-1:0];
      else begin
         if (s >= (IW+1)'(N)) s = s - (IW+1)'(N);
         wrap_add = s[IW-1:0];
      end
   endfunction

   always_comb begin
      hit = 1'b0;
      win = start_q;
      for (int o = 0; o < N; o++) begin
         logic [IW-1:0] cand;
         cand = wrap_add(start_q, IW'(o));
         if (!hit && req[cand]) begin
            hit = 1'b1;
            win = cand;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         gnt_vld <= 1'b0;
         gnt_idx <= '0;
      end else begin
         gnt_vld <= hit;
         gnt_idx <= win;
         if (hit) start_q <= wrap_add(win, IW'(1));
      end
   end

   // R4
   pick_from_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld |-> (((($past(req)) >> gnt_idx) & N'(1)) != '0));
   // R5
   idle_without_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|req) |=> !gnt_vld);
   // R4
   grant_on_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |=> gnt_vld);
endmodule

// File: rtl/dispatch_arbiter.sv
module dispatch_arbiter #(
   parameter int unsigned N_SRC   = 7,
   parameter int unsigned N_LANE  = 4,
   parameter int unsigned DEPTH   = 16,
   parameter int unsigned THR_RST = 2,
   parameter int unsigned STALL_W = 16,
   parameter int unsigned CW      = $clog2(DEPTH + 1),
   parameter int unsigned IW      = dsa_pkg::idx_bits(N_SRC)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_SRC-1:0]     src_valid,
   input  logic [N_LANE*CW-1:0] lane_occ,
   input  logic                 cfg_thr_we,
   input  logic [CW-1:0]        cfg_thr_data,
   input  logic                 cfg_mask_we,
   input  logic [IW-1:0]        cfg_mask_sel,
   input  logic [N_LANE-1:0]    cfg_mask_data,
   output logic                 grant_valid,
   output logic [IW-1:0]        grant_idx,
   output logic [STALL_W-1:0]   stall_count
);
   localparam logic [STALL_W-1:0] STALL_MAX = '1;

   if (N_SRC < 2) begin : g_bad_src
      $error("dispatch_arbiter: N_SRC must be at least 2");
   end
   if (THR_RST > DEPTH) begin : g_bad_thr
      $error("dispatch_arbiter: THR_RST exceeds DEPTH");
   end
   if (STALL_W < 1) begin : g_bad_stall
      $error("dispatch_arbiter: STALL_W must be positive");
   end

   logic [CW-1:0]     thr_q;
   logic [N_LANE-1:0] mask_q [N_SRC];
   logic [N_LANE-1:0] lane_ok;
   logic [N_SRC-1:0]  elig;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_q <= CW'(THR_RST);
         for (int s = 0; s < N_SRC; s++)
            mask_q[s] <= N_LANE'(dsa_pkg::base_lanes(s));
      end else begin
         if (cfg_thr_we) thr_q <= cfg_thr_data;
         if (cfg_mask_we && (int'(cfg_mask_sel) < N_SRC))
            mask_q[cfg_mask_sel] <= cfg_mask_data;
      end
   end

   lane_room_check #(.N_LANE(N_LANE), .DEPTH(DEPTH), .CW(CW)) u_room (
      .occ_flat (lane_occ),
      .thr      (thr_q),
      .lane_ok  (lane_ok)
   );

   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      assign elig[s] = src_valid[s] & (&(lane_ok | ~mask_q[s]));
   end

   rr_pick #(.N(N_SRC), .IW(IW)) u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (elig),
      .gnt_vld (grant_valid),
      .gnt_idx (grant_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stall_count <= '0;
      else if ((|src_valid) && !(|elig) && (stall_count != STALL_MAX))
         stall_count <= stall_count + 1'b1;
   end

   // R2
   grant_had_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> (((($past(src_valid)) >> grant_idx) & N_SRC'(1)) != '0));
   // R10
   stall_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|src_valid) && !(|elig) && (stall_count != STALL_MAX))
      |=> (stall_count == $past(stall_count) + 1'b1));
   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|src_valid) || (|elig)) |=> $stable(stall_count));
endmodule

// File: tb/dispatch_arbiter_test.sv
module dispatch_arbiter_test;
   localparam int CLK_PERIOD = 10;
   localparam int NS = 7, NL = 4, DP = 16, CW = 5, IW = 3, SW = 6;
   localparam int SMAX = (1 << SW) - 1;

   logic clk = 0, rst_n = 0;
   logic [NS-1:0]    src_valid = '0;
   logic [NL*CW-1:0] lane_occ = '0;
   logic             cfg_thr_we = 0, cfg_mask_we = 0;
   logic [CW-1:0]    cfg_thr_data = '0;
   logic [IW-1:0]    cfg_mask_sel = '0;
   logic [NL-1:0]    cfg_mask_data = '0;
   logic             grant_valid;
   logic [IW-1:0]    grant_idx;
   logic [SW-1:0]    stall_count;

   int checks = 0, failures = 0;
   int m_thr, m_ptr, m_stall;
   int m_mask [NS];
   int occ_tab [4] = '{0, 14, 15, 16};

   always #(CLK_PERIOD/2) clk = ~clk;

   dispatch_arbiter #(.N_SRC(NS), .N_LANE(NL), .DEPTH(DP), .STALL_W(SW)) uut (
      .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .lane_occ(lane_occ),
      .cfg_thr_we(cfg_thr_we), .cfg_thr_data(cfg_thr_data),
      .cfg_mask_we(cfg_mask_we), .cfg_mask_sel(cfg_mask_sel),
      .cfg_mask_data(cfg_mask_data), .grant_valid(grant_valid),
      .grant_idx(grant_idx), .stall_count(stall_count));

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit src_ok(input int s);
      if (!src_valid[s]) return 0;
      for (int k = 0; k < NL; k++) begin
         int occ, room;
         occ  = int'(lane_occ[k*CW +: CW]);
         room = (occ > DP) ? 0 : DP - occ;
         if (((m_mask[s] >> k) & 1) && room < m_thr) return 0;
      end
      return 1;
   endfunction

   // One decision: predict, clock, compare at the following falling edge.
   task automatic decide(input string tag);
      int ev, ei;
      ev = 0; ei = 0;
      for (int o = 0; o < NS; o++) begin
         int c;
         c = (m_ptr + o) % NS;
         if (ev == 0 && src_ok(c)) begin ev = 1; ei = c; end
      end
      if (ev == 0 && src_valid != 0 && m_stall < SMAX) m_stall++;
      @(posedge clk); @(negedge clk);
      if (ev == 0) check({tag, " R5"}, int'(grant_valid), 0);
      else check({tag, " R2/R4/R6 idx"}, grant_valid ? int'(grant_idx) : -1, ei);
      check("R10 stall", int'(stall_count), m_stall);
      if (ev != 0) m_ptr = (ei + 1) % NS;
   endtask

   task automatic set_occ(input int op);
      for (int k = 0; k < NL; k++)
         lane_occ[k*CW +: CW] = CW'(occ_tab[(op >> (2*k)) & 3]);
   endtask

   task automatic cfg_cycle();
      src_valid = '0;
      @(posedge clk); @(negedge clk);
      cfg_thr_we = 0; cfg_mask_we = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      m_thr = 2; m_ptr = 0; m_stall = 0;
      // R9 baseline masks
      m_mask = '{4'b0101, 4'b0011, 4'b0110, 4'b0000, 4'b0010, 4'b0000, 4'b0100};
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 grant_valid", int'(grant_valid), 0);
      check("R1 stall_count", int'(stall_count), 0);
      rst_n = 1;
      @(negedge clk);
      check("R1 idle after reset", int'(grant_valid), 0);

      // R11: source 0 needs lanes 0,2; lanes 1,3 full
      lane_occ = '0;
      lane_occ[1*CW +: CW] = 5'd16; lane_occ[3*CW +: CW] = 5'd16;
      src_valid = 7'b0000001;
      decide("R11 unmasked lanes full");
      // R3: source 3 (empty mask) with all lanes full
      for (int k = 0; k < NL; k++) lane_occ[k*CW +: CW] = 5'd16;
      src_valid = 7'b0001000;
      decide("R3 empty mask");

      // Sweep all head patterns against occupancy around threshold 2 (R2, R9)
      for (int v = 0; v < 128; v++)
         for (int op = 0; op < 256; op++) begin
            src_valid = NS'(v);
            set_occ(op);
            decide("R9 sweep");
         end
      check("R10 saturated", int'(stall_count), SMAX);

      // R7 threshold rewrite, R8 mask rewrites incl. out-of-range select
      cfg_thr_we = 1; cfg_thr_data = 5'd3; cfg_cycle(); m_thr = 3;
      cfg_mask_we = 1; cfg_mask_sel = 3'd3; cfg_mask_data = 4'b1000; cfg_cycle();
      m_mask[3] = 4'b1000;
      cfg_mask_we = 1; cfg_mask_sel = 3'd5; cfg_mask_data = 4'b1111; cfg_cycle();
      m_mask[5] = 4'b1111;
      cfg_mask_we = 1; cfg_mask_sel = 3'd7; cfg_mask_data = 4'b1111; cfg_cycle();

      // R7 boundary: occ 14 gives 2 free, now below threshold 3
      for (int k = 0; k < NL; k++) lane_occ[k*CW +: CW] = 5'd14;
      src_valid = 7'b1000000;
      decide("R7 threshold 3");
      // R8 out-of-range select left masks alone: source 6 still only lane 2
      for (int k = 0; k < NL; k++) lane_occ[k*CW +: CW] = 5'd16;
      lane_occ[2*CW +: CW] = 5'd0;
      src_valid = 7'b1000000;
      decide("R8 sel 7 ignored");

      for (int v = 0; v < 128; v++)
         for (int op = 0; op < 256; op += 17) begin
            src_valid = NS'(v);
            set_occ(op);
            decide("R8 sweep");
         end

      finish_run();
   end
endmodule